// File: doc/BRIEF.md
# Word-Selecting Signed Multiplier

This execution unit sits in a 64-bit datapath. Each source operand holds two 32-bit words: the low word in bits 31:0 and the high word in bits 63:32. A 2-bit operation code chooses one word from each operand, and the unit multiplies the two words as two's-complement integers. The result is the complete 64-bit signed product.

The choice of words is fixed and asymmetric. The first operand gives its low word, except in the high-by-high operation. The second operand gives its low word only in the low-by-low operation. There is no operation that takes the high word of the first operand with the low word of the second. The last code point is reserved. If it is issued, the result is zero and an illegal-operation flag is raised.

The unit is fully pipelined. It accepts a new operation in every cycle and returns each result a fixed number of cycles later, in the order the operations were issued. The number of stages and the multiplier structure (a single product, or two partial products summed in a later stage) are parameters.

Top module: `wsel_mul`

## Requirements
- R1: Word 0 of an operand is bits 31:0 and word 1 is bits 63:32. Each selected word is read as a signed two's-complement value.
- R2: Op code 2'b00 returns operand1.word0 × operand2.word0. This is the same as a plain signed 32×32→64 multiply of the low words.
- R3: Op code 2'b01 returns operand1.word0 × operand2.word1.
- R4: Op code 2'b10 returns operand1.word1 × operand2.word1.
- R5: The product is the full 64-bit signed result, with no truncation and no saturation. 0x80000000 × 0x80000000 gives 0x4000000000000000.
- R6: Op code 2'b11 is reserved. Its result has out_illegal high and out_data zero.
- R7: in_ready is high in every cycle. Every cycle with in_valid high produces exactly one out_valid, and results leave in issue order.
- R8: With LATENCY=4, an operation accepted at rising edge N shows out_valid and its data after rising edge N+3. That is the fourth edge, counting the accepting edge.
- R9: A synchronous active-high reset clears every pipeline valid bit. out_valid stays low until a new operation arrives.
- R10: out_illegal is low for every result of a legal op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | Always high; an operation is accepted in any cycle |
| in_op | input | 2 | 00 low×low, 01 low×high, 10 high×high, 11 reserved |
| in_rs1 | input | 64 | First source operand |
| in_rs2 | input | 64 | Second source operand |
| out_valid | output | 1 | Result valid, one cycle per accepted operation |
| out_illegal | output | 1 | The result belongs to the reserved op code |
| out_data | output | 64 | Signed 64-bit product, or zero for the reserved code |

## Verification
For every operation it issues, the bench records the edge at which the unit captures it. It expects the matching result at the negedge after the third following edge, so the result is due four edges after capture, counting the capturing edge.

At each negedge the bench reads out_valid. It pops the oldest pending entry and compares the data, the illegal flag and the edge number, which checks the R8 latency and the R7 ordering together.

After a mid-stream reset it expects no out_valid at all for several cycles. The sweep sends one operation in every cycle, so all four stages are full at the same time.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
   typedef enum logic [1:0] {
      WSEL_LOLO = 2'b00,
      WSEL_LOHI = 2'b01,
      WSEL_HIHI = 2'b10,
      WSEL_RSVD = 2'b11
   } wsel_op_e;
endpackage

// File: rtl/wsel_pick.sv
// Chooses the multiplier inputs from the two operands and flags the reserved code.
module wsel_pick #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]   rs1,
   input  logic [XLEN-1:0]   rs2,
   input  logic [1:0]        op,
   output logic [XLEN/2-1:0] mcand,
   output logic [XLEN/2-1:0] mplier,
   output logic              illegal
);
   import wsel_pkg::*;
   localparam int HALF = XLEN / 2;

   initial begin
      assert (XLEN % 2 == 0 && XLEN >= 8)
         else $fatal(1, "wsel_pick: XLEN must be even and at least 8");
   end

   wsel_op_e op_e;
   assign op_e = wsel_op_e'(op);

   always_comb begin
      mcand   = rs1[HALF-1:0];
      mplier  = rs2[HALF-1:0];
      illegal = 1'b0;
      unique case (op_e)
         WSEL_LOLO: begin
            mcand  = rs1[HALF-1:0];
            mplier = rs2[HALF-1:0];
         end
         WSEL_LOHI: begin
            mcand  = rs1[HALF-1:0];
            mplier = rs2[XLEN-1:HALF];
         end
         WSEL_HIHI: begin
            mcand  = rs1[XLEN-1:HALF];
            mplier = rs2[XLEN-1:HALF];
         end
         default: begin
            mcand   = '0;
            mplier  = '0;
            illegal = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/wsel_delay.sv
// Plain register delay line; zero depth is a wire.
module wsel_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W >= 1 && DEPTH >= 0) else $fatal(1, "wsel_delay: bad parameters");
   end

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] sr [DEPTH];
         always_ff @(posedge clk) begin
            sr[0] <= d;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
         end
         assign q = sr[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/wsel_valid_pipe.sv
// Valid shift chain; the only state that reset touches.
module wsel_valid_pipe #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vin,
   output logic [DEPTH-1:0] vstg
);
   initial begin
      assert (DEPTH >= 2) else $fatal(1, "wsel_valid_pipe: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) vstg <= '0;
      else     vstg <= {vstg[DEPTH-2:0], vin};
   end

   // R9: after a reset edge no stage holds a valid operation
   a_r9_flush: assert property (@(posedge clk) rst |=> (vstg == '0));
endmodule

// File: rtl/wsel_mul_pipe.sv
// Pipelined signed HALF x HALF -> 2*HALF multiplier with a sideband tag.
module wsel_mul_pipe #(
   parameter int HALF   = 32,
   parameter int STAGES = 4,
   parameter bit SPLIT  = 1'b1,
   parameter int TAGW   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_v,
   input  logic [HALF-1:0]   in_a,
   input  logic [HALF-1:0]   in_b,
   input  logic [TAGW-1:0]   in_tag,
   output logic              out_v,
   output logic [2*HALF-1:0] out_prod,
   output logic [TAGW-1:0]   out_tag
);
   localparam int PW     = 2 * HALF;
   localparam int CORE   = SPLIT ? 3 : 2;
   localparam int TAIL   = STAGES - CORE;
   localparam int LO     = HALF / 2;
   localparam int HB     = HALF - LO;
   localparam logic [HALF-1:0] MINV  = {1'b1, {(HALF-1){1'b0}}};
   localparam logic [PW-1:0]   MINSQ = {2'b01, {(PW-2){1'b0}}};

   initial begin
      assert (STAGES >= CORE) else $fatal(1, "wsel_mul_pipe: STAGES too small for variant");
      assert (HALF >= 4)      else $fatal(1, "wsel_mul_pipe: HALF too small");
   end

   function automatic logic [PW-1:0] sx(input logic [HALF-1:0] x);
      return {{HALF{x[HALF-1]}}, x};
   endfunction

   logic [STAGES-1:0] vstg;
   logic [HALF-1:0]   a_q, b_q;
   logic [TAGW-1:0]   tag_q;
   logic [PW-1:0]     core_prod;

   wsel_valid_pipe #(.DEPTH(STAGES)) u_vld (
      .clk (clk),
      .rst (rst),
      .vin (in_v),
      .vstg(vstg)
   );

   always_ff @(posedge clk) begin
      a_q   <= in_a;
      b_q   <= in_b;
      tag_q <= in_tag;
   end

   generate
      if (SPLIT) begin : g_split
         logic [PW-1:0] pl_n, ph_n, pl_q, ph_q, sum_q;
         always_comb begin
            pl_n = sx(a_q) * {{(PW-LO){1'b0}}, b_q[LO-1:0]};
            ph_n = sx(a_q) * {{(PW-HB){b_q[HALF-1]}}, b_q[HALF-1:LO]};
         end
         always_ff @(posedge clk) begin
            pl_q  <= pl_n;
            ph_q  <= ph_n;
            sum_q <= pl_q + (ph_q << LO);
         end
         assign core_prod = sum_q;

         // R5: most negative squared reaches the positive 2^(PW-2)
         a_r5_min_square: assert property (@(posedge clk) disable iff (rst)
            (vstg[0] && a_q == MINV && b_q == MINV) |=> ##1 (sum_q == MINSQ));
         // R1: a multiplicand of all ones is -1, so the sum negates the multiplier
         a_r1_neg_one: assert property (@(posedge clk) disable iff (rst)
            (vstg[0] && a_q == '1) |=> ##1 (sum_q == (~sx($past(b_q, 2)) + 1'b1)));
      end else begin : g_direct
         logic [PW-1:0] prod_q;
         always_ff @(posedge clk) prod_q <= sx(a_q) * sx(b_q);
         assign core_prod = prod_q;

         a_r5_min_square: assert property (@(posedge clk) disable iff (rst)
            (vstg[0] && a_q == MINV && b_q == MINV) |=> (prod_q == MINSQ));
         a_r1_neg_one: assert property (@(posedge clk) disable iff (rst)
            (vstg[0] && a_q == '1) |=> (prod_q == (~sx($past(b_q)) + 1'b1)));
      end
   endgenerate

   wsel_delay #(.W(PW), .DEPTH(TAIL)) u_tail (
      .clk(clk),
      .d  (core_prod),
      .q  (out_prod)
   );

   wsel_delay #(.W(TAGW), .DEPTH(STAGES-1)) u_tag (
      .clk(clk),
      .d  (tag_q),
      .q  (out_tag)
   );

   assign out_v = vstg[STAGES-1];
endmodule

// File: rtl/wsel_mul.sv
// Top: word selection, pipelined signed multiply, reserved-code zeroing.
module wsel_mul #(
   parameter int XLEN      = 64,
   parameter int LATENCY   = 4,
   parameter bit SPLIT_MUL = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [1:0]      in_op,
   input  logic [XLEN-1:0] in_rs1,
   input  logic [XLEN-1:0] in_rs2,
   output logic            out_valid,
   output logic            out_illegal,
   output logic [XLEN-1:0] out_data
);
   localparam int HALF = XLEN / 2;
   localparam int CW   = $clog2(LATENCY + 1) + 1;

   initial begin
      assert (LATENCY >= (SPLIT_MUL ? 3 : 2))
         else $fatal(1, "wsel_mul: LATENCY too small for the chosen multiplier");
   end

   logic [HALF-1:0] mcand, mplier;
   logic            sel_ill;
   logic            pipe_ill;
   logic [XLEN-1:0] pipe_prod;

   assign in_ready = 1'b1;

   wsel_pick #(.XLEN(XLEN)) u_pick (
      .rs1    (in_rs1),
      .rs2    (in_rs2),
      .op     (in_op),
      .mcand  (mcand),
      .mplier (mplier),
      .illegal(sel_ill)
   );

   wsel_mul_pipe #(.HALF(HALF), .STAGES(LATENCY), .SPLIT(SPLIT_MUL), .TAGW(1)) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .in_v    (in_valid),
      .in_a    (mcand),
      .in_b    (mplier),
      .in_tag  (sel_ill),
      .out_v   (out_valid),
      .out_prod(pipe_prod),
      .out_tag (pipe_ill)
   );

   assign out_illegal = pipe_ill;
   assign out_data    = pipe_ill ? '0 : pipe_prod;

   // In-flight bookkeeping used only by the checks below.
   logic [CW-1:0] inflight, ill_inflight;
   always_ff @(posedge clk) begin
      if (rst) begin
         inflight     <= '0;
         ill_inflight <= '0;
      end else begin
         inflight     <= inflight + CW'(in_valid) - CW'(out_valid);
         ill_inflight <= ill_inflight + CW'(in_valid && in_op == 2'b11)
                                      - CW'(out_valid && out_illegal);
      end
   end

   // R7: every result matches an accepted operation, and no more than LATENCY are pending
   a_r7_no_orphan: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (inflight != '0));
   a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
      inflight <= CW'(LATENCY));
   // R6: an illegal result only appears for an accepted reserved code
   a_r6_illegal_tracked: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_illegal) |-> (ill_inflight != '0));
endmodule

// File: tb/sim_wsel_mul.sv
module sim_wsel_mul;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = 2'b00;
   logic [63:0] in_rs1 = '0;
   logic [63:0] in_rs2 = '0;
   logic        out_valid;
   logic        out_illegal;
   logic [63:0] out_data;

   int checks = 0;
   int fails  = 0;
   int edge_cnt = 0;

   logic [63:0] exp_q [$];
   logic        ill_q [$];
   int          stamp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   wsel_mul #(.XLEN(64), .LATENCY(LAT), .SPLIT_MUL(1'b1)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_rs1(in_rs1), .in_rs2(in_rs2),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
   );

   function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      logic [31:0] x, y;
      longint sx, sy;
      if (op == 2'b11) return 64'd0;
      x = (op == 2'b10) ? a[63:32] : a[31:0];
      y = (op == 2'b00) ? b[31:0] : b[63:32];
      sx = $signed(x);
      sy = $signed(y);
      return sx * sy;
   endfunction

   function automatic string req_of(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      logic [31:0] x, y;
      x = (op == 2'b10) ? a[63:32] : a[31:0];
      y = (op == 2'b00) ? b[31:0] : b[63:32];
      if (op == 2'b11) return "R6";
      if (x == 32'h8000_0000 && y == 32'h8000_0000) return "R5";
      if (op == 2'b00) return "R1 R2";
      if (op == 2'b01) return "R1 R3";
      return "R1 R4";
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_rs1   = a;
      in_rs2   = b;
      exp_q.push_back(model(op, a, b));
      ill_q.push_back(op == 2'b11);
      stamp_q.push_back(edge_cnt + 1);
      tag_q.push_back(req_of(op, a, b));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Result monitor: sample on the falling edge, away from the register updates
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", out_data, 64'd0);
         end else begin
            logic [63:0] e;
            logic        il;
            int          st;
            string       tg;
            e  = exp_q.pop_front();
            il = ill_q.pop_front();
            st = stamp_q.pop_front();
            tg = tag_q.pop_front();
            check(out_data == e, tg, out_data, e);
            check(out_illegal == il, il ? "R6 flag" : "R10 flag",
                  64'(out_illegal), 64'(il));
            check(edge_cnt == st + LAT - 1, "R8 latency",
                  64'(edge_cnt), 64'(st + LAT - 1));
         end
      end
   end

   logic [31:0] corner [6];

   initial begin
      corner[0] = 32'h0000_0000;
      corner[1] = 32'h0000_0001;
      corner[2] = 32'hFFFF_FFFF;
      corner[3] = 32'h8000_0000;
      corner[4] = 32'h7FFF_FFFF;
      corner[5] = 32'h5A5A_A5A5;

      repeat (3) @(negedge clk);
      // R9: outputs idle out of reset; R7: ready held high
      check(out_valid == 1'b0, "R9 reset state", 64'(out_valid), 64'd0);
      check(in_ready == 1'b1, "R7 ready", 64'(in_ready), 64'd1);
      @(negedge clk);
      rst = 1'b0;

      // R5 directed corner: min x min
      issue(2'b00, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
      issue(2'b10, 64'h8000_0000_0000_0000, 64'h8000_0000_1234_5678);
      issue(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_7FFF_FFFF);

      // Mid-stream reset flushes the three in flight (R9)
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      exp_q.delete(); ill_q.delete(); stamp_q.delete(); tag_q.delete();
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < LAT + 2; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R9 flush", 64'(out_valid), 64'd0);
      end

      issue(2'b00, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);

      // Corner sweep: every op, every corner in every half, back-to-back
      for (int op = 0; op < 4; op++)
         for (int p = 0; p < 6; p++)
            for (int q = 0; q < 6; q++)
               for (int r = 0; r < 6; r++)
                  for (int s = 0; s < 6; s++)
                     issue(2'(op), {corner[q], corner[p]}, {corner[s], corner[r]});

      // Random operands with occasional bubbles
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 5) == 0) idle(1);
         issue(2'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom});
      end

      idle(LAT + 4);
      // R7: one result per accepted operation, nothing left pending
      check(exp_q.size() == 0, "R7 drain", 64'(exp_q.size()), 64'd0);
      check(in_ready == 1'b1, "R7 ready", 64'(in_ready), 64'd1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finish", edge_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule